// File: doc/BRIEF.md
# Quadrant-Coded Pixel Phase Edge Generator

This block splits every pixel period into 48 equal phase steps and places programmable edges on them. A fast clock at 48 times the pixel rate advances a phase counter. A pixel-start marker restarts that counter. Four programmable codes give the rising and falling positions of a horizontal clock and of a reset gate. A fifth code gives the step at which the output data word changes.

The block drives two in-phase horizontal clocks (`hclk_a`, `hclk_b`) and their complements (`hclk_a_n`, `hclk_b_n`). It also drives a reset-gate output and a one-cycle data-change strobe. Each code is six bits wide. The top two bits pick a quarter of the period, and the low four bits give an offset of 0 to 11 inside that quarter.

A code whose offset is 12 to 15 does not name any step. Such a code disables its edge and raises a sticky error flag. Codes are held in shadow registers that reload only when a new period begins, so a change made in the middle of a period cannot disturb the waveform.

Top module: `pixel_phase_edgegen`

## Requirements
- R1: The phase counter counts 0 to 47 and wraps from 47 to 0. When `pix_start` is sampled high, the counter is 0 on the next cycle, whatever its value was.
- R2: The location of a code is (code[5:4] × 12) + code[3:0]. For example, code 0x1B is location 23 and code 0x3B is location 47.
- R3: A code with code[3:0] in the range 12 to 15 is illegal. Its edge never fires, and the affected output keeps the level it already has.
- R4: `code_err` rises one cycle after an illegal code reaches the shadow registers. It stays high until `rst`, and legal codes loaded later do not clear it.
- R5: An output goes high one fast-clock cycle after the counter equals its rising location. It goes low one fast-clock cycle after the counter equals its falling location.
- R6: When the rising and falling locations are both legal and equal, the output keeps its current level for the whole period.
- R7: `hclk_a` and `hclk_b` follow the horizontal edge codes identically. `hclk_a_n` is always the inverse of `hclk_a`, and `hclk_b_n` is always the inverse of `hclk_b`.
- R8: `rgate` follows its own rising and falling codes under the same rules as R5, R3 and R6.
- R9: `dout_strobe` is high for exactly the one cycle after the counter equals the data-phase location. An illegal data-phase code produces no strobe.
- R10: All five codes are captured on the clock edge at which the counter enters 0, either by wrap or by `pix_start`. A code change at any other time has no effect until that edge.
- R11: While `rst` is high, all outputs are in their reset state: `hclk_a`, `hclk_b`, `rgate`, `dout_strobe` and `code_err` are 0, and `hclk_a_n` and `hclk_b_n` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, 48 steps per pixel period |
| rst | input | 1 | Synchronous active-high reset |
| pix_start | input | 1 | Pixel-start marker; restarts the phase count |
| hclk_rise_code | input | 6 | Quadrant code of the horizontal clock rising edge |
| hclk_fall_code | input | 6 | Quadrant code of the horizontal clock falling edge |
| rgate_rise_code | input | 6 | Quadrant code of the reset-gate rising edge |
| rgate_fall_code | input | 6 | Quadrant code of the reset-gate falling edge |
| dout_phase_code | input | 6 | Quadrant code of the data-change step |
| hclk_a | output | 1 | Horizontal clock, first copy |
| hclk_a_n | output | 1 | Inverse of `hclk_a` |
| hclk_b | output | 1 | Horizontal clock, second copy |
| hclk_b_n | output | 1 | Inverse of `hclk_b` |
| rgate | output | 1 | Reset-gate output |
| dout_strobe | output | 1 | One-cycle pulse at the data-change step |
| code_err | output | 1 | Sticky flag for an illegal code |

## Verification
The bench places edges at both ends of each quadrant, including offset 11 and location 47. A decoder that multiplied by 16 instead of 12 would put these edges on the wrong cycles. A decoder that forgot the wrap would lose the strobe at step 47.

Illegal offsets are mixed with legal ones in the same configuration. A design that decoded them anyway would toggle an output the bench expects to stay flat. Equal rising and falling positions are applied while the output is high, which catches a design where one of the two edges wins.

A code change in the middle of a period catches a design without shadow registers, because that design would change its waveform early. A mid-period `pix_start` catches a counter that ignores the restart, because its strobe would arrive on the old schedule.

// File: rtl/edgegen_pkg.sv
package edgegen_pkg;
  // Index of each programmable code in the code arrays.
  localparam int IDX_HRISE = 0;
  localparam int IDX_HFALL = 1;
  localparam int IDX_RRISE = 2;
  localparam int IDX_RFALL = 3;
  localparam int IDX_DOUT  = 4;
  localparam int NUM_CODES = 5;

  // Output channels: two horizontal copies and the reset gate.
  localparam int NUM_CH = 3;

  function automatic int ch_rise_idx(input int ch);
    return (ch == NUM_CH - 1) ? IDX_RRISE : IDX_HRISE;
  endfunction

  function automatic int ch_fall_idx(input int ch);
    return (ch == NUM_CH - 1) ? IDX_RFALL : IDX_HFALL;
  endfunction
endpackage

// File: rtl/phase_counter.sv
module phase_counter #(
  parameter int PHASES = 48,
  parameter int CNT_W  = $clog2(PHASES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pix_start,
  output logic [CNT_W-1:0] cnt,
  output logic             load
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PHASES - 1);

  // The next value is 0 either on a restart or on a wrap.
  assign load = pix_start || (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (load) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end

  // R1
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt == LAST) |=> (cnt == '0));

  // R1
  restart_chk: assert property (@(posedge clk) disable iff (rst)
    pix_start |=> (cnt == '0));
endmodule

// File: rtl/edge_code_decoder.sv
module edge_code_decoder #(
  parameter int CODE_W = 6,
  parameter int QSTEPS = 12,
  parameter int CNT_W  = 6
) (
  input  logic [CODE_W-1:0] code,
  output logic [CNT_W-1:0]  loc,
  output logic              ok
);
  localparam int OFF_W = 4;
  localparam int QD_W  = CODE_W - OFF_W;

  logic [QD_W-1:0]  quad;
  logic [OFF_W-1:0] off;

  assign quad = code[CODE_W-1:OFF_W];
  assign off  = code[OFF_W-1:0];
  assign ok   = (int'(off) < QSTEPS);
  assign loc  = CNT_W'(int'(quad) * QSTEPS + int'(off));
endmodule

// File: rtl/edge_level_gen.sv
module edge_level_gen #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] rise_loc,
  input  logic             rise_ok,
  input  logic [CNT_W-1:0] fall_loc,
  input  logic             fall_ok,
  output logic             lvl,
  output logic             lvl_n
);
  logic hold, hit_rise, hit_fall;

  assign hold     = rise_ok && fall_ok && (rise_loc == fall_loc);
  assign hit_rise = rise_ok && (cnt == rise_loc);
  assign hit_fall = fall_ok && (cnt == fall_loc);

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl   <= 1'b0;
      lvl_n <= 1'b1;
    end else if (!hold) begin
      if (hit_rise) begin
        lvl   <= 1'b1;
        lvl_n <= 1'b0;
      end else if (hit_fall) begin
        lvl   <= 1'b0;
        lvl_n <= 1'b1;
      end
    end
  end

  // R5
  rise_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (rise_ok && cnt == rise_loc && !(fall_ok && fall_loc == rise_loc)) |=> lvl);

  // R5
  fall_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (fall_ok && cnt == fall_loc && !(rise_ok && rise_loc == fall_loc)) |=> !lvl);

  // R6
  equal_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rise_ok && fall_ok && rise_loc == fall_loc) |=> $stable(lvl));

  // R3
  no_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (!rise_ok && !fall_ok) |=> $stable(lvl));

  // R7
  pair_inverse_chk: assert property (@(posedge clk) disable iff (rst)
    lvl_n != lvl);
endmodule

// File: rtl/pixel_phase_edgegen.sv
module pixel_phase_edgegen
  import edgegen_pkg::*;
#(
  parameter int PHASES = 48,
  parameter int QSTEPS = 12,
  parameter int CODE_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pix_start,
  input  logic [CODE_W-1:0] hclk_rise_code,
  input  logic [CODE_W-1:0] hclk_fall_code,
  input  logic [CODE_W-1:0] rgate_rise_code,
  input  logic [CODE_W-1:0] rgate_fall_code,
  input  logic [CODE_W-1:0] dout_phase_code,
  output logic              hclk_a,
  output logic              hclk_a_n,
  output logic              hclk_b,
  output logic              hclk_b_n,
  output logic              rgate,
  output logic              dout_strobe,
  output logic              code_err
);
  localparam int CNT_W = $clog2(PHASES);

  logic [CNT_W-1:0]  cnt;
  logic              load;
  logic [CODE_W-1:0] live_code [NUM_CODES];
  logic [CODE_W-1:0] shd_code  [NUM_CODES];
  logic [CNT_W-1:0]  dec_loc   [NUM_CODES];
  logic [NUM_CODES-1:0] dec_ok;
  logic [NUM_CH-1:0] ch_lvl, ch_lvl_n;

  assign live_code[IDX_HRISE] = hclk_rise_code;
  assign live_code[IDX_HFALL] = hclk_fall_code;
  assign live_code[IDX_RRISE] = rgate_rise_code;
  assign live_code[IDX_RFALL] = rgate_fall_code;
  assign live_code[IDX_DOUT]  = dout_phase_code;

  phase_counter #(.PHASES(PHASES), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .pix_start(pix_start), .cnt(cnt), .load(load)
  );

  // Shadow capture and decode, one slice per code.
  for (genvar g = 0; g < NUM_CODES; g++) begin : g_code
    always_ff @(posedge clk) begin
      if (rst)       shd_code[g] <= '0;
      else if (load) shd_code[g] <= live_code[g];
    end

    edge_code_decoder #(.CODE_W(CODE_W), .QSTEPS(QSTEPS), .CNT_W(CNT_W)) u_dec (
      .code(shd_code[g]), .loc(dec_loc[g]), .ok(dec_ok[g])
    );
  end

  // Edge channels.
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int RI = ch_rise_idx(c);
    localparam int FI = ch_fall_idx(c);
    edge_level_gen #(.CNT_W(CNT_W)) u_edge (
      .clk(clk), .rst(rst), .cnt(cnt),
      .rise_loc(dec_loc[RI]), .rise_ok(dec_ok[RI]),
      .fall_loc(dec_loc[FI]), .fall_ok(dec_ok[FI]),
      .lvl(ch_lvl[c]), .lvl_n(ch_lvl_n[c])
    );
  end

  assign hclk_a   = ch_lvl[0];
  assign hclk_a_n = ch_lvl_n[0];
  assign hclk_b   = ch_lvl[1];
  assign hclk_b_n = ch_lvl_n[1];
  assign rgate    = ch_lvl[NUM_CH-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      dout_strobe <= 1'b0;
      code_err    <= 1'b0;
    end else begin
      dout_strobe <= dec_ok[IDX_DOUT] && (cnt == dec_loc[IDX_DOUT]);
      code_err    <= code_err || !(&dec_ok);
    end
  end

  // R4
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    code_err |=> code_err);

  // R7
  copies_match_chk: assert property (@(posedge clk) disable iff (rst)
    (hclk_a == hclk_b) && (hclk_b_n != hclk_b));

  // R8
  rgate_pair_chk: assert property (@(posedge clk) disable iff (rst)
    ch_lvl_n[NUM_CH-1] != rgate);

  // R9
  strobe_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (dout_strobe && !pix_start && cnt != '0) |=> !dout_strobe);
endmodule

// File: tb/pixel_phase_edgegen_bench.sv
module pixel_phase_edgegen_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, pix_start;
  logic [5:0] hr, hf, rr, rf, dp;
  logic h1, h2, h3, h4, rg, dstb, err;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  pixel_phase_edgegen u_pixel_phase_edgegen (
    .clk(clk), .rst(rst), .pix_start(pix_start),
    .hclk_rise_code(hr), .hclk_fall_code(hf),
    .rgate_rise_code(rr), .rgate_fall_code(rf), .dout_phase_code(dp),
    .hclk_a(h1), .hclk_a_n(h2), .hclk_b(h3), .hclk_b_n(h4),
    .rgate(rg), .dout_strobe(dstb), .code_err(err)
  );

  // Rows: {hrise, hfall, rrise, rfall, dphase}
  localparam logic [29:0] VEC [5] = '{
    {6'h00, 6'h20, 6'h01, 6'h03, 6'h00},
    {6'h1B, 6'h3B, 6'h10, 6'h05, 6'h3B},
    {6'h35, 6'h02, 6'h2A, 6'h2B, 6'h16},
    {6'h0C, 6'h14, 6'h0F, 6'h22, 6'h1C},
    {6'h27, 6'h3F, 6'h30, 6'h00, 6'h25}
  };

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int cloc(logic [5:0] c);
    return int'(c[5:4]) * 12 + int'(c[3:0]);
  endfunction

  function automatic bit cok(logic [5:0] c);
    return c[3:0] < 4'd12;
  endfunction

  // Expected level in steady state at step j: the latest legal edge at or before j-1.
  function automatic bit exp_lvl(logic [5:0] rc, logic [5:0] fc, int j);
    int last = (j + 47) % 48;
    int best = -1;
    bit val = 0;
    if (cok(rc) && cloc(rc) <= last) begin best = cloc(rc); val = 1; end
    if (cok(fc) && cloc(fc) <= last && cloc(fc) > best) begin best = cloc(fc); val = 0; end
    if (best < 0) begin
      if (cok(rc)) begin best = cloc(rc); val = 1; end
      if (cok(fc) && cloc(fc) > best) begin best = cloc(fc); val = 0; end
    end
    return val;
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_cfg(logic [29:0] c);
    {hr, hf, rr, rf, dp} = c;
  endtask

  task automatic pulse_start();
    pix_start = 1'b1;
    step();
    pix_start = 1'b0;
  endtask

  task automatic check_step(logic [29:0] c, int j);
    logic [5:0] a, b, x, y, d;
    bit eh, er, es;
    string th, tr;
    {a, b, x, y, d} = c;
    eh = exp_lvl(a, b, j);
    er = exp_lvl(x, y, j);
    es = cok(d) && (((cloc(d) + 1) % 48) == j);
    th = (cok(a) && cok(b)) ? "R5/R2" : "R3";
    tr = (cok(x) && cok(y)) ? "R8/R2" : "R8/R3";
    chk(h1 == eh, th, $sformatf("hclk_a step %0d", j), h1, eh);
    chk(h3 == eh, "R7", $sformatf("hclk_b step %0d", j), h3, eh);
    chk(h2 == !eh && h4 == !eh, "R7", $sformatf("complements step %0d", j), {h2, h4}, {!eh, !eh});
    chk(rg == er, tr, $sformatf("rgate step %0d", j), rg, er);
    chk(dstb == es, "R9", $sformatf("strobe step %0d", j), dstb, es);
  endtask

  initial begin
    #800000;
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit exp_err;
    rst = 1'b1; pix_start = 1'b0;
    set_cfg('0);
    @(negedge clk);
    repeat (3) step();
    // R11
    chk({h1, h2, h3, h4, rg, dstb, err} == 7'b0101000, "R11", "reset outputs",
        {h1, h2, h3, h4, rg, dstb, err}, 7'b0101000);
    rst = 1'b0;

    // Table walk: load at start, skip the settling period, check the next.
    exp_err = 0;
    for (int i = 0; i < 5; i++) begin
      set_cfg(VEC[i]);
      pulse_start();
      repeat (48) step();
      for (int j = 0; j < 48; j++) begin
        check_step(VEC[i], j);
        step();
      end
      if (!(cok(hr) && cok(hf) && cok(rr) && cok(rf) && cok(dp))) exp_err = 1;
      // R4
      chk(err == exp_err, "R4", $sformatf("code_err after row %0d", i), err, exp_err);
    end

    // R10: a change mid-period waits for the next period start.
    set_cfg(VEC[0]);
    pulse_start();
    repeat (48) step();
    for (int j = 0; j < 48; j++) begin
      if (j == 10) set_cfg(VEC[2]);
      check_step(VEC[0], j);
      step();
    end
    repeat (48) step();
    for (int j = 0; j < 48; j++) begin
      check_step(VEC[2], j);
      step();
    end

    // R6: equal edges keep the high level.
    set_cfg({6'h2A, 6'h0A, 6'h2A, 6'h0A, 6'h00});
    pulse_start();
    repeat (48) step();
    chk(h1 == 1'b1 && rg == 1'b1, "R6", "high before hold", {h1, rg}, 2'b11);
    set_cfg({6'h07, 6'h07, 6'h07, 6'h07, 6'h00});
    repeat (48) step();
    for (int j = 0; j < 96; j++) begin
      chk(h1 == 1'b1 && rg == 1'b1, "R6", $sformatf("hold step %0d", j), {h1, rg}, 2'b11);
      step();
    end

    // R1: mid-period restart moves the strobe schedule.
    set_cfg({6'h00, 6'h20, 6'h01, 6'h03, 6'h05});
    pulse_start();
    repeat (20) step();
    pulse_start();
    for (int j = 0; j < 48; j++) begin
      chk(dstb == (j == 6), "R1", $sformatf("strobe after restart step %0d", j), dstb, (j == 6));
      step();
    end

    // R4: sticky until reset.
    chk(err == 1'b1, "R4", "code_err still set", err, 1);
    rst = 1'b1;
    step();
    chk(err == 1'b0, "R4", "code_err cleared by reset", err, 0);
    rst = 1'b0;
    step();

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule